// File: doc/BRIEF.md
# I2C Slave Address Matcher with Don't-Care Mask

This block recognises its own slave address on an I2C bus and answers the address phase with an acknowledge. It watches SCL and SDA through synchronizers, finds START, repeated START and STOP, shifts in address bytes and compares them with a programmed own address. A five-bit mask turns chosen own-address bits into don't-cares, so one slave answers a whole group of addresses. A 7-bit mode and a 10-bit mode are supported, and the mask maps onto the address bits differently in each.

When an address is fully matched, the byte actually received is kept in a readable buffer and an interrupt pulse is raised. Software reads the buffer to learn which of the accepted addresses was used. The block only drives SDA low for the acknowledge bit. It does nothing with data bytes, does not stretch the clock, and never acts as a master.

Top module: `i2c_mask_addr_match`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the block to idle. No byte is acknowledged after that until a START (SDA falling while SCL is high) has been seen.
- R2: In 7-bit mode (`cfg_ten_bit`=0) the received byte's bits 7:1 are compared with `own_addr_lo` bits 7:1. `addr_mask[k]`=1 makes address bit k+1 a don't-care, for k = 0 to 4. Bits 7 and 6 are always compared. Bit 0, the R/W bit, is never compared.
- R3: With own address A0h and `addr_mask`=00111b in 7-bit mode, exactly the even byte values A0h to AEh (with either R/W value) are acknowledged.
- R4: In 10-bit mode the first byte must equal 11110, then `own_addr_hi[1:0]`, then 0 (write). When it does, the block acknowledges it and expects a low-address byte. The upper address bits are never masked.
- R5: In 10-bit mode the low byte is compared with all 8 bits of `own_addr_lo`. `addr_mask[4:1]` masks low bits 5:2, and `addr_mask[0]` masks low bits 1 and 0 together. With low address A0h and mask 00111b, low values A0h to AFh are accepted.
- R6: In 10-bit mode a first byte of 11110, then `own_addr_hi`, then 1 (read) is acknowledged only when the preceding first and low bytes matched, with no STOP since then. It is otherwise refused.
- R7: `sda_drive_low` goes high only after the SCL falling edge that ends the eighth bit of a matching byte. It is released at the SCL falling edge that ends the ninth clock.
- R8: On a complete match (a 7-bit address, a 10-bit low byte, or an accepted 10-bit read header), `rx_addr_buf` takes the received byte and `match_irq` is high for exactly one clock. A refused byte leaves the buffer unchanged and raises no interrupt.
- R9: After a refused byte, later bytes are ignored until a START. A repeated START restarts address reception at once.
- R10: After reset `sda_drive_low`=0, `match_irq`=0 and `rx_addr_buf`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| own_addr_lo | input | 8 | Own address (7-bit: bits 7:1; 10-bit: low byte) |
| own_addr_hi | input | 2 | Upper two bits of the 10-bit own address |
| addr_mask | input | 5 | Don't-care mask; bit k covers address bit k+1 |
| rx_addr_buf | output | 8 | Last fully matched address byte |
| match_irq | output | 1 | One-cycle pulse on a complete match |

## Verification
Three 7-bit configurations are tried: the documented A0h/00111b case, an all-ones mask, and an empty mask. Between them they separate the masked low bits from the never-masked bits 7 and 6, and they show that the R/W bit is ignored. A 10-bit sweep of the low byte under mask 00111b shows that the combined mask bit covers bits 1:0, and a narrow mask of 00001b bounds it to those two bits. Header bytes with the wrong upper bits, reads without a prior match, bytes sent after a STOP or after a refused byte, and a repeated START separate the bus-sequencing rules from the comparison itself.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_LOW,
    ST_LOW_ACK,
    ST_SKIP
  } am_state_t;

  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  // Bits that take part in a 7-bit compare: 7:6 always, 5:1 unless masked, bit 0 (R/W) never.
  function automatic logic [7:0] care_7b(input logic [4:0] m);
    return {2'b11, ~m, 1'b0};
  endfunction

  // Bits that take part in a 10-bit low-byte compare: mask bit 0 covers address bits 1 and 0.
  function automatic logic [7:0] care_10b(input logic [4:0] m);
    return {2'b11, ~m[4:1], ~m[0], ~m[0]};
  endfunction

  function automatic logic match_7b(input logic [7:0] rx, input logic [7:0] own,
                                    input logic [4:0] m);
    return ((rx ^ own) & care_7b(m)) == 8'h00;
  endfunction

  function automatic logic match_10lo(input logic [7:0] rx, input logic [7:0] own,
                                      input logic [4:0] m);
    return ((rx ^ own) & care_10b(m)) == 8'h00;
  endfunction

  function automatic logic hdr_is(input logic [7:0] rx, input logic [1:0] hi,
                                  input logic rd);
    return (rx[7:3] == TEN_BIT_TAG) && (rx[2:1] == hi) && (rx[0] == rd);
  endfunction

endpackage

// File: rtl/i2c_am_bus_sync.sv
module i2c_am_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_in};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = sda_prev & ~sda_s & scl_s & scl_prev;
  assign stop_evt  = ~sda_prev & sda_s & scl_s & scl_prev;

  // Bus events are mutually exclusive in any one cycle (R1)
  assert_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data,
  output logic              full
);
  localparam int CW = $clog2(BYTE_W + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift && !full) begin
      cnt  <= cnt + 1'b1;
      data <= {data[BYTE_W-2:0], bit_in};
    end
  end

  assign full = (cnt == CW'(BYTE_W));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BYTE_W));

endmodule

// File: rtl/i2c_am_compare.sv
module i2c_am_compare
  import i2c_am_pkg::*;
(
  input  logic       ten_bit,
  input  logic       in_low,
  input  logic       ten_ok,
  input  logic [7:0] rx,
  input  logic [7:0] own_lo,
  input  logic [1:0] own_hi,
  input  logic [4:0] mask,
  output logic       hit,
  output logic       final_hit,
  output logic       go_low,
  output logic       read_hit
);
  logic wr_hdr, rd_hdr, m7, m10;

  assign wr_hdr = hdr_is(rx, own_hi, 1'b0);
  assign rd_hdr = hdr_is(rx, own_hi, 1'b1) & ten_ok;
  assign m7     = match_7b(rx, own_lo, mask);
  assign m10    = match_10lo(rx, own_lo, mask);

  always_comb begin
    hit       = 1'b0;
    final_hit = 1'b0;
    go_low    = 1'b0;
    read_hit  = 1'b0;
    if (in_low) begin
      hit       = m10;
      final_hit = m10;
    end else if (!ten_bit) begin
      hit       = m7;
      final_hit = m7;
    end else begin
      hit       = wr_hdr | rd_hdr;
      final_hit = rd_hdr;
      go_low    = wr_hdr;
      read_hit  = rd_hdr;
    end
  end

endmodule

// File: rtl/i2c_mask_addr_match.sv
module i2c_mask_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_drive_low,
  input  logic        cfg_ten_bit,
  input  logic [7:0]  own_addr_lo,
  input  logic [1:0]  own_addr_hi,
  input  logic [4:0]  addr_mask,
  output logic [7:0]  rx_addr_buf,
  output logic        match_irq
);
  am_state_t state;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_full, hit, final_hit, go_low, read_hit;
  logic ack_q, irq_q, ten_ok_q, to_low_q;
  logic [7:0] buf_q;
  logic in_ack, in_addr, decide, sh_clear;

  i2c_am_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign in_ack   = (state == ST_HDR_ACK) || (state == ST_LOW_ACK);
  assign in_addr  = (state == ST_HDR) || (state == ST_LOW);
  assign sh_clear = start_evt | (in_ack & scl_fall);
  assign decide   = in_addr & scl_fall & byte_full;

  i2c_am_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift(scl_rise & in_addr),
    .bit_in(sda_s), .data(rx_byte), .full(byte_full)
  );

  i2c_am_compare u_cmp (
    .ten_bit(cfg_ten_bit), .in_low(state == ST_LOW), .ten_ok(ten_ok_q),
    .rx(rx_byte[7:0]), .own_lo(own_addr_lo), .own_hi(own_addr_hi), .mask(addr_mask),
    .hit(hit), .final_hit(final_hit), .go_low(go_low), .read_hit(read_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_q    <= 1'b0;
      irq_q    <= 1'b0;
      ten_ok_q <= 1'b0;
      to_low_q <= 1'b0;
      buf_q    <= '0;
    end else begin
      irq_q <= 1'b0;
      if (stop_evt) begin
        state    <= ST_IDLE;
        ack_q    <= 1'b0;
        ten_ok_q <= 1'b0;
      end else if (start_evt) begin
        state <= ST_HDR;
        ack_q <= 1'b0;
      end else begin
        case (state)
          ST_HDR, ST_LOW: begin
            if (decide) begin
              if (state == ST_HDR && !read_hit) ten_ok_q <= 1'b0;
              if (hit) begin
                ack_q    <= 1'b1;
                to_low_q <= go_low;
                state    <= (state == ST_HDR) ? ST_HDR_ACK : ST_LOW_ACK;
                if (final_hit) begin
                  buf_q <= rx_byte[7:0];
                  irq_q <= 1'b1;
                end
                if (state == ST_LOW) ten_ok_q <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_HDR_ACK: if (scl_fall) begin
            ack_q <= 1'b0;
            state <= to_low_q ? ST_LOW : ST_SKIP;
          end
          ST_LOW_ACK: if (scl_fall) begin
            ack_q <= 1'b0;
            state <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low = ack_q;
  assign match_irq     = irq_q;
  assign rx_addr_buf   = buf_q;

  // SDA is only pulled during an acknowledge clock
  assert_drive_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> in_ack);
  // The pull starts while SCL is low
  assert_drive_starts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);
  // Interrupt is a single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);
  // Interrupt only accompanies an acknowledge
  assert_irq_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> sda_drive_low);
  // STOP idles the block
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_drive_low);
  // START releases SDA and restarts reception
  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_HDR) && !sda_drive_low);
  // An accepted 10-bit read header needs a prior full 10-bit match
  assert_read_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && cfg_ten_bit && state == ST_HDR_ACK) |-> ten_ok_q);

endmodule

// File: tb/i2c_mask_addr_match_bench.sv
module i2c_mask_addr_match_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, drv, irq, ten;
  logic [7:0] own_lo, buf_v;
  logic [1:0] own_hi;
  logic [4:0] mask;
  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~drv;

  i2c_mask_addr_match u_i2c_mask_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(drv), .cfg_ten_bit(ten), .own_addr_lo(own_lo),
    .own_addr_hi(own_hi), .addr_mask(mask), .rx_addr_buf(buf_v), .match_irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q);
    acked = drv;
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    check("R7 release after ninth clock", drv, 0);
  endtask

  function automatic logic exp7(input logic [7:0] b, input logic [7:0] o, input logic [4:0] m);
    for (int n = 1; n <= 7; n++) begin
      if (n <= 5 && m[n-1]) continue;
      if (b[n] != o[n]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic exp10(input logic [7:0] b, input logic [7:0] o, input logic [4:0] m);
    for (int n = 0; n <= 7; n++) begin
      if (n >= 2 && n <= 5 && m[n-1]) continue;
      if (n <= 1 && m[0]) continue;
      if (b[n] != o[n]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic one7(input logic [7:0] b, input string tag);
    logic a, e;
    logic [7:0] old_buf;
    int old_irq;
    old_buf = buf_v; old_irq = irq_cnt;
    e = exp7(b, own_lo, mask);
    bus_start;
    send_byte(b, a);
    check(tag, a, e);
    check("R8 buffer", buf_v, e ? b : old_buf);
    check("R8 irq count", irq_cnt, old_irq + (e ? 1 : 0));
    bus_stop;
  endtask

  task automatic sweep7(input string tag);
    for (int a = 0; a < 128; a++) one7({a[6:0], a[0] ^ a[3]}, tag);
  endtask

  initial begin
    logic ak;
    logic [7:0] lb;
    ten = 1'b0; own_lo = 8'hA0; own_hi = 2'b00; mask = 5'b00111;
    tick(4);
    check("R10 drive at reset", drv, 0);
    check("R10 irq at reset", irq, 0);
    check("R10 buffer at reset", buf_v, 0);
    rst_n = 1'b1; tick(4);

    sweep7("R3 A0h/00111 7-bit");
    own_lo = 8'h6C; mask = 5'b11111;
    sweep7("R2 all-ones mask");
    mask = 5'b00000;
    one7(8'h6C, "R2 exact match");
    one7(8'h6D, "R2 read bit ignored");
    one7(8'h6E, "R2 bit1 unmasked");

    // R1: no acknowledge after STOP without START
    bus_start; bus_stop;
    send_byte(8'h6C, ak);
    check("R1 no ack after stop", ak, 0);
    bus_stop;

    // R9: refused byte then ignore, repeated START restarts
    bus_start;
    send_byte(8'h10, ak); check("R9 refused", ak, 0);
    send_byte(8'h6C, ak); check("R9 ignored after refuse", ak, 0);
    bus_start;
    send_byte(8'h6D, ak); check("R9 repeated start ack", ak, 1);
    bus_stop;

    // 10-bit mode
    ten = 1'b1; own_hi = 2'b10; own_lo = 8'hA0; mask = 5'b00111;
    bus_start;
    send_byte(8'hF6, ak); check("R4 wrong upper bits", ak, 0);
    bus_stop;
    for (int v = 128; v < 256; v++) begin
      logic [7:0] old_buf;
      int old_irq;
      logic e;
      lb = v[7:0];
      e = exp10(lb, own_lo, mask);
      old_buf = buf_v; old_irq = irq_cnt;
      bus_start;
      send_byte(8'hF4, ak); check("R4 write header", ak, 1);
      send_byte(lb, ak); check("R5 low byte sweep", ak, e);
      check("R8 buffer 10-bit", buf_v, e ? lb : old_buf);
      check("R8 irq 10-bit", irq_cnt, old_irq + (e ? 1 : 0));
      bus_stop;
    end

    // R6 read header
    bus_start;
    send_byte(8'hF4, ak); send_byte(8'hA5, ak);
    check("R6 low matched", ak, 1);
    bus_start;
    send_byte(8'hF5, ak); check("R6 read after match", ak, 1);
    check("R6 buffer holds read header", buf_v, 8'hF5);
    bus_stop;
    bus_start;
    send_byte(8'hF5, ak); check("R6 read after stop", ak, 0);
    bus_stop;
    bus_start;
    send_byte(8'hF4, ak); send_byte(8'h10, ak);
    check("R6 low refused", ak, 0);
    bus_start;
    send_byte(8'hF5, ak); check("R6 read after refused low", ak, 0);
    bus_stop;

    // R5 narrow mask: bit 0 covers two low bits only
    mask = 5'b00001;
    bus_start; send_byte(8'hF4, ak); send_byte(8'hA3, ak);
    check("R5 mask bit0 covers bits 1:0", ak, 1);
    bus_stop;
    bus_start; send_byte(8'hF4, ak); send_byte(8'hA4, ak);
    check("R5 bit2 still compared", ak, 0);
    bus_stop;

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule